// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block models a 2048-by-8 static memory with a second, shadow array of the same size that survives supply loss. Four active-low control inputs select one of four operations: chip enable `ce_n`, output enable `oe_n`, write enable `we_n` and shadow enable `ne_n`. The operations are a byte read, a byte write, a bulk store that copies every SRAM byte into the shadow array, and a bulk recall that copies the shadow array back into the SRAM. All inputs are sampled on the rising clock edge. The store and recall cycles last a fixed number of clocks, each set by a parameter.

A `supply_ok` input reports the state of the supply. A low level latches a recall request. When the supply is good again, the recall runs by itself, and nothing else can start until it has finished. Reset behaves like a power-up, so the first thing the block does after reset is a recall. The data bus is split into an input, an output and an output-enable. The enable is high only for a read while no bulk cycle is running or pending.

Top module: `shadow_sram_ctl`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `we_n`=1, `ne_n`=1, no bulk cycle running and no recall pending, `dq_oe` is 1 and `dq_o` shows the byte at `addr` in the same cycle.
- R2: A write is selected by `ce_n`=0, `we_n`=0, `ne_n`=1. It stores the `addr` and `dq_i` of its last selected cycle when `ce_n` or `we_n` rises. If it is left by `ne_n` falling, nothing is written.
- R3: `dq_oe` is 0 whenever `we_n` is 0, including a write with `oe_n` low.
- R4: A store is selected by `ce_n`=0, `we_n`=0, `ne_n`=0, `oe_n`=1. It copies the whole SRAM into the shadow, leaves the SRAM unchanged, and holds `busy` high for exactly STORE_CYC cycles.
- R5: A recall is selected by `ce_n`=0, `oe_n`=0, `ne_n`=0, `we_n`=1. It leaves the SRAM equal to the shadow and the shadow unchanged, so it can be repeated, and holds `busy` high for exactly RECALL_CYC cycles.
- R6: A store or recall starts only on the cycle its selecting state is first sampled. Holding that state starts no further cycle.
- R7: While `busy` is high, every control, address and data input is ignored and `dq_oe` is 0.
- R8: If the pins select a read in the cycle `busy` falls after a recall, `dq_oe` is 1 in that cycle with the recalled data.
- R9: A cycle with `supply_ok`=0 latches a recall request. While the supply is low or the request is pending, no operation starts and `dq_oe` is 0. Once `supply_ok` is 1 again, a recall of RECALL_CYC cycles starts on the next clock.
- R10: During reset `busy` and `dq_oe` are 0 and the shadow is cleared to zero. Reset latches a recall request, so a recall runs as soon as the supply is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, acts as power-up |
| supply_ok | input | 1 | High while the supply is above its good threshold |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| ne_n | input | 1 | Shadow enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_i | input | DATA_W | Write data |
| dq_o | output | DATA_W | Read data |
| dq_oe | output | 1 | Data output enable |
| busy | output | 1 | High during a store or recall cycle |

## Verification
The read result (`dq_oe`, `dq_o`) follows the pins combinationally, so the bench checks it about one nanosecond after it changes the pins, within the same cycle. A write becomes visible after the clock edge that samples the rising `ce_n` or `we_n`. A bulk cycle raises `busy` after the edge that samples its selecting state, and `busy` drops again after exactly STORE_CYC or RECALL_CYC further edges. All checks therefore sample 1 ns after a rising edge and count edges from the start edge. The bench keeps a reference copy of both arrays that it updates only at the edges named above.

// File: rtl/shadow_sram_ctl.sv
module shadow_sram_ctl #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int STORE_CYC  = 16,
  parameter int RECALL_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              ne_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXC  = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CNT_W = $clog2(MAXC) + 1;

  typedef enum logic [1:0] {IDLE, STORE, RECALL} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic              pend, st_q, rc_q, wr_q;
  logic [ADDR_W-1:0] wa;
  logic [DATA_W-1:0] wd;
  logic [DATA_W-1:0] mem    [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];

  wire sel_rd = !ce_n && !oe_n &&  we_n &&  ne_n;
  wire sel_wr = !ce_n && !we_n &&  ne_n;
  wire sel_st = !ce_n && !we_n && !ne_n &&  oe_n;
  wire sel_rc = !ce_n && !oe_n && !ne_n &&  we_n;

  wire idle    = (st == IDLE);
  wire free    = idle && !pend && supply_ok;
  wire go_auto = idle && pend && supply_ok;
  wire go_rc   = free && sel_rc && !rc_q;
  wire go_st   = free && sel_st && !st_q;
  wire start_rc = go_auto || go_rc;
  wire last    = !idle && (cnt == '0);
  wire commit  = free && wr_q && (ce_n || we_n);

  assign busy  = !idle;
  assign dq_oe = sel_rd && free;
  assign dq_o  = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      cnt  <= '0;
      pend <= 1'b1;
      st_q <= 1'b0;
      rc_q <= 1'b0;
      wr_q <= 1'b0;
      wa   <= '0;
      wd   <= '0;
    end else begin
      st_q <= sel_st;
      rc_q <= sel_rc;
      wr_q <= free && sel_wr;
      if (free && sel_wr) begin
        wa <= addr;
        wd <= dq_i;
      end
      if (!supply_ok) pend <= 1'b1;
      else if (go_auto) pend <= 1'b0;
      case (st)
        IDLE: begin
          if (start_rc) begin
            st  <= RECALL;
            cnt <= CNT_W'(RECALL_CYC - 1);
          end else if (go_st) begin
            st  <= STORE;
            cnt <= CNT_W'(STORE_CYC - 1);
          end
        end
        default: begin
          if (cnt == '0) st <= IDLE;
          else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (start_rc) mem <= '{default: '0};
    else if (last && st == RECALL) mem <= shadow;
    else if (commit) mem[wa] <= wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow <= '{default: '0};
    else if (last && st == STORE) shadow <= mem;
  end
endmodule

module shadow_sram_ctl_chk #(
  parameter int STORE_CYC  = 16,
  parameter int RECALL_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic we_n,
  input logic dq_oe,
  input logic busy
);
  int unsigned blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blen <= 0;
    else if (busy) blen <= blen + 1;
    else blen <= 0;
  end

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dq_oe);

  // R3
  wr_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dq_oe);

  // R9
  low_supply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && !busy) |=> !busy);

  // R4 R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen == STORE_CYC || blen == RECALL_CYC));
endmodule

bind shadow_sram_ctl shadow_sram_ctl_chk #(
  .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .we_n(we_n),
  .dq_oe(dq_oe), .busy(busy)
);

// File: tb/shadow_sram_ctl_tb.sv
`timescale 1ns/1ps
module shadow_sram_ctl_tb;
  localparam int AW = 11, DW = 8, SC = 16, RC = 8, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, supply_ok = 1;
  logic ce_n = 1, oe_n = 1, we_n = 1, ne_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_i = '0, dq_o;
  logic dq_oe, busy;
  logic [DW-1:0] em [DEPTH];
  logic [DW-1:0] es [DEPTH];
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  shadow_sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYC(SC), .RECALL_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .ne_n(ne_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe(dq_oe), .busy(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic pins(input logic c, input logic o, input logic w, input logic n);
    ce_n = c; oe_n = o; we_n = w; ne_n = n;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    pins(0, 0, 1, 1); addr = a; #1;
    chk({req, " oe"}, dq_oe, 1);
    chk({req, " data"}, dq_o, em[a]);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit oe_lo, input bit by_ce);
    pins(0, oe_lo ? 1'b0 : 1'b1, 0, 1); addr = a; dq_i = d; #1;
    chk("R3 drivers off in write", dq_oe, 0);
    cyc();
    if (by_ce) ce_n = 1; else we_n = 1;
    cyc();
    em[a] = d;
  endtask

  task automatic wait_busy(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk({req, " busy"}, busy, 1);
      chk("R7 no drive while busy", dq_oe, 0);
      cyc();
    end
    chk({req, " busy end"}, busy, 0);
  endtask

  task automatic do_store();
    pins(1, 1, 1, 1); cyc();
    pins(0, 1, 0, 0); cyc();
    for (int i = 0; i < DEPTH; i++) es[i] = em[i];
    wait_busy(SC, "R4");
  endtask

  task automatic do_recall();
    pins(1, 1, 1, 1); cyc();
    pins(0, 0, 1, 0); cyc();
    for (int i = 0; i < DEPTH; i++) em[i] = es[i];
    wait_busy(RC, "R5");
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin em[i] = '0; es[i] = '0; end
    // R10 reset state
    pins(0, 0, 1, 1);
    repeat (3) cyc();
    chk("R10 busy in reset", busy, 0);
    chk("R10 oe in reset", dq_oe, 0);
    pins(1, 1, 1, 1);
    rst_n = 1;
    cyc();
    wait_busy(RC, "R10 power-up recall");
    rd_chk(11'd5, "R10 cleared shadow");

    // R1 R2 R3 writes ended by we, by ce, with oe low
    wr(11'd1, 8'hA5, 0, 0);
    wr(11'd2, 8'h3C, 1, 0);
    wr(11'd2047, 8'h7E, 0, 1);
    rd_chk(11'd1, "R2 we end");
    rd_chk(11'd2, "R2 oe low");
    rd_chk(11'd2047, "R1 top addr");

    // R4 store, then R6 hold gives no second cycle
    do_store();
    for (int i = 0; i < 3; i++) begin chk("R6 no retrigger", busy, 0); cyc(); end
    rd_chk(11'd1, "R4 sram unchanged");

    // R5 overwrite, recall twice
    wr(11'd1, 8'h00, 0, 0);
    wr(11'd3, 8'hFF, 0, 0);
    do_recall();
    for (int i = 0; i < DEPTH; i++) rd_chk(i[AW-1:0], "R5 recall contents");
    wr(11'd2, 8'h11, 0, 0);
    do_recall();
    rd_chk(11'd2, "R5 repeat recall");
    rd_chk(11'd1, "R5 repeat recall");

    // R7 inputs ignored during store
    pins(1, 1, 1, 1); cyc();
    pins(0, 1, 0, 0); cyc();
    for (int i = 0; i < DEPTH; i++) es[i] = em[i];
    pins(0, 1, 0, 1); addr = 11'd9; dq_i = 8'h99; cyc();
    pins(1, 1, 1, 1); cyc();
    pins(0, 0, 1, 0); cyc();
    pins(1, 1, 1, 1);
    wait_busy(SC - 3, "R7");
    rd_chk(11'd9, "R7 write ignored");
    cyc();
    chk("R7 recall ignored", busy, 0);

    // R8 read active in cycle recall ends
    wr(11'd1, 8'h44, 0, 0);
    pins(1, 1, 1, 1); cyc();
    pins(0, 0, 1, 0); cyc();
    for (int i = 0; i < DEPTH; i++) em[i] = es[i];
    pins(0, 0, 1, 1); addr = 11'd1;
    for (int i = 0; i < RC; i++) begin chk("R8 busy", busy, 1); chk("R8 quiet", dq_oe, 0); cyc(); end
    chk("R8 oe at end", dq_oe, 1);
    chk("R8 data at end", dq_o, es[1]);

    // R2 write left by ne falling: no commit, store starts
    pins(0, 1, 0, 1); addr = 11'd4; dq_i = 8'hC3; cyc();
    pins(0, 1, 0, 0); cyc();
    for (int i = 0; i < DEPTH; i++) es[i] = em[i];
    wait_busy(SC, "R2 ne exit store");
    rd_chk(11'd4, "R2 no commit on ne exit");

    // R9 supply loss
    wr(11'd6, 8'h66, 0, 0);
    supply_ok = 0; pins(1, 1, 1, 1); cyc();
    pins(0, 1, 0, 0); cyc();
    chk("R9 no store when low", busy, 0);
    pins(0, 0, 1, 1); addr = 11'd6; #1;
    chk("R9 no drive when low", dq_oe, 0);
    pins(1, 1, 1, 1); cyc();
    chk("R9 still idle", busy, 0);
    supply_ok = 1; cyc();
    for (int i = 0; i < DEPTH; i++) em[i] = es[i];
    wait_busy(RC, "R9 auto recall");
    rd_chk(11'd6, "R9 recalled data");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned r;
      logic [AW-1:0] a;
      r = $urandom % 20;
      a = AW'($urandom % 32);
      if (r < 10) wr(a, DW'($urandom), r[0], r[1]);
      else if (r < 16) rd_chk(a, "R1 random read");
      else if (r < 18) begin pins(1, 1, 1, 1); cyc(); end
      else if (r == 18) do_store();
      else do_recall();
    end
    for (int i = 0; i < 32; i++) rd_chk(i[AW-1:0], "R1 final sweep");

    summary();
    $finish;
  end
endmodule